// File: doc/BRIEF.md
# Inter-Core Message Interrupt Controller

This block lets each core of a small multi-core cluster post a short message interrupt to any core in the cluster, itself included. Every core owns a pair of 32-bit registers in a small register window. One is a command (control) register that the core writes. The other is a mailbox (status) register that holds the last message delivered to that core. A single control write can do two things. It can deliver a 16-bit payload, tagged with the writer's core index, to a chosen destination core and raise that core's interrupt line. It can also acknowledge the writer's own pending message and drop the writer's interrupt line.

The register port is word addressed, so the byte-offset bits are not brought in. Word address bit 0 selects control (0) or status (1). The bits above it select the core. Reads return data one cycle after the request. Each core has one level interrupt output that stays high while that core's mailbox holds a pending message.

Top module: `ipi_ctrl`

## Requirements
- R1: The word address is decoded with bit 0 selecting the control register (0) or the status register (1), and bits 2:1 giving the core index. An access reaches at most one core's register.
- R2: A write to a control register of a core in range stores all 32 data bits, and a later read of that register returns them unchanged.
- R3: Writes to a status register change no register and no interrupt output.
- R4: A control write with bit 30 set and destination field bits 29:16 naming a core in range loads that core's status with bit 31 = 0, bit 30 = 1, bits 29:16 = the writer's index and bits 15:0 = the written bits 15:0. It also raises that core's interrupt on the next cycle.
- R5: A new message replaces any earlier pending message at the destination, with no queueing.
- R6: A control write with bit 31 set clears only bit 30 of the writer's own status, keeps bits 29:0, and lowers the writer's interrupt.
- R7: When one write sets both bits 31 and 30, delivery is applied first and acknowledge second. A core that targets itself therefore ends with its message stored and its pending bit clear.
- R8: A read request returns the addressed register on rdata one cycle later, and rdata holds its value between reads.
- R9: Accesses to a core index at or above NUM_CORES read as zero and, when written, change nothing.
- R10: A delivery whose destination field is at or above NUM_CORES updates no status and raises no interrupt.
- R11: After reset, all control and status registers read zero and all interrupt outputs are low.
- R12: Each interrupt output is a level equal to its core's status bit 30 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read request, data returned next cycle |
| word_addr | input | 3 | Word address: bit 0 register select, bits 2:1 core index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | NUM_CORES | One level interrupt per core |

## Verification
The bench runs with three cores, so the fourth slot of the window is out of range and both out-of-range rules can be exercised. Messages are sent between distinct cores to show that the sender index and payload land in the right mailbox. A second message to the same core shows that it overwrites the first. A write to a status register shows that status writes are ignored. Combined delivery-and-acknowledge writes are tried both on the writer itself and on another core, which separates the ordering rule from a plain acknowledge. Destination fields just past the core count and at the field maximum show that out-of-range delivery is dropped. Each interrupt line is compared against a behavioural mailbox model on every clock.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int MAX_CORES = 4;
  localparam int CIDX_W    = $clog2(MAX_CORES);
  localparam int WADDR_W   = CIDX_W + 1;
  localparam int DATA_W    = 32;
  localparam int ID_W      = 14;
  localparam int PAY_W     = 16;

  typedef struct packed {
    logic             ack;
    logic             gen;
    logic [ID_W-1:0]  dest;
    logic [PAY_W-1:0] payload;
  } ctrl_t;

  typedef struct packed {
    logic             rsvd;
    logic             pend;
    logic [ID_W-1:0]  src;
    logic [PAY_W-1:0] payload;
  } stat_t;

  function automatic logic [CIDX_W-1:0] core_of(input logic [WADDR_W-1:0] a);
    return a[WADDR_W-1:1];
  endfunction

  function automatic logic is_status(input logic [WADDR_W-1:0] a);
    return a[0];
  endfunction

  function automatic stat_t make_status(input logic [CIDX_W-1:0] src,
                                        input logic [PAY_W-1:0]  pay);
    stat_t s;
    s.rsvd    = 1'b0;
    s.pend    = 1'b1;
    s.src     = ID_W'(src);
    s.payload = pay;
    return s;
  endfunction
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WADDR_W-1:0]   word_addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_CORES-1:0] ctrl_we,
  output logic [NUM_CORES-1:0] gen_hit,
  output logic [NUM_CORES-1:0] ack_hit,
  output logic [CIDX_W-1:0]    src_idx
);
  ctrl_t cmd;
  logic  src_ok;
  logic  ctrl_wr;

  assign cmd     = ctrl_t'(wdata);
  assign src_idx = core_of(word_addr);
  assign src_ok  = int'(src_idx) < NUM_CORES;
  assign ctrl_wr = wr_en && !is_status(word_addr) && src_ok;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    assign ctrl_we[i] = ctrl_wr && (src_idx == CIDX_W'(i));
    assign gen_hit[i] = ctrl_wr && cmd.gen && (cmd.dest == ID_W'(i));
    assign ack_hit[i] = ctrl_we[i] && cmd.ack;
  end

  p_one_core_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_we));
  p_dest_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cmd.dest) >= NUM_CORES) |-> (gen_hit == '0));
  p_status_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_status(word_addr)) |-> (ctrl_we == '0 && ack_hit == '0 && gen_hit == '0));
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              gen_hit,
  input  logic              ack_hit,
  input  logic [CIDX_W-1:0] src_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output stat_t             stat_q,
  output logic              irq_o
);
  stat_t stat_d;

  always_comb begin
    stat_d = stat_q;
    if (gen_hit) stat_d = make_status(src_idx, wdata[PAY_W-1:0]);
    if (ack_hit) stat_d.pend = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      stat_q <= stat_d;
      irq_o  <= stat_d.pend;
    end
  end

  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(wdata)));
  p_gen_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_hit && !ack_hit) |=> (irq_o && stat_q.payload == $past(wdata[PAY_W-1:0])));
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !gen_hit) |=> (!irq_o && $stable(stat_q.src) && $stable(stat_q.payload)));
  p_both_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && gen_hit) |=> (!stat_q.pend && stat_q.src == ID_W'($past(src_idx))));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_hit && !ack_hit) |=> $stable(stat_q));
  p_irq_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == stat_q.pend);
endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_en,
  input  logic [WADDR_W-1:0]               word_addr,
  input  logic [NUM_CORES-1:0][DATA_W-1:0] ctrl_all,
  input  logic [NUM_CORES-1:0][DATA_W-1:0] stat_all,
  output logic [DATA_W-1:0]                rdata
);
  logic [CIDX_W-1:0] core;
  logic [DATA_W-1:0] sel;

  assign core = core_of(word_addr);

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (core == CIDX_W'(i))
        sel = is_status(word_addr) ? stat_all[i] : ctrl_all[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(core) >= NUM_CORES) |=> (rdata == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [WADDR_W-1:0]   word_addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_CORES-1:0] irq
);
  logic [NUM_CORES-1:0]             ctrl_we, gen_hit, ack_hit;
  logic [CIDX_W-1:0]                src_idx;
  logic [NUM_CORES-1:0][DATA_W-1:0] ctrl_all, stat_all;

  initial begin
    if (NUM_CORES < 1 || NUM_CORES > MAX_CORES)
      $error("NUM_CORES out of supported range");
  end

  ipi_addr_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_addr(word_addr),
    .wdata(wdata), .ctrl_we(ctrl_we), .gen_hit(gen_hit),
    .ack_hit(ack_hit), .src_idx(src_idx)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
    stat_t st;
    ipi_core_slot u_slot (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we[i]), .gen_hit(gen_hit[i]),
      .ack_hit(ack_hit[i]), .src_idx(src_idx), .wdata(wdata),
      .ctrl_q(ctrl_all[i]), .stat_q(st), .irq_o(irq[i])
    );
    assign stat_all[i] = DATA_W'(st);
  end

  ipi_read_mux #(.NUM_CORES(NUM_CORES)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .word_addr(word_addr),
    .ctrl_all(ctrl_all), .stat_all(stat_all), .rdata(rdata)
  );
endmodule

// File: tb/ipi_ctrl_bench.sv
module ipi_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  word_addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] irq;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [31:0] ctrl_m [4];
  logic [31:0] stat_m [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_ctrl #(.NUM_CORES(N)) u_ipi_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .word_addr(word_addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R12: every clock, each interrupt line must match the model's pending bit
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++)
        check("R12 irq level", 32'(irq[i]), 32'(stat_m[i][30]));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(int core, bit status, logic [31:0] d);
    int dst;
    @(negedge clk);
    wr_en = 1; word_addr = {2'(core), status}; wdata = d;
    @(posedge clk);
    #1;
    if (!status && core < N) begin
      ctrl_m[core] = d;
      dst = int'(d[29:16]);
      if (d[30] && dst < N) stat_m[dst] = {2'b01, 14'(core), d[15:0]};
      if (d[31]) stat_m[core][30] = 1'b0;
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int core, bit status, string req);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1; word_addr = {2'(core), status};
    exp = (core >= N) ? 32'h0 : (status ? stat_m[core] : ctrl_m[core]);
    @(negedge clk);
    rd_en = 0;
    check(req, rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin ctrl_m[i] = '0; stat_m[i] = '0; end
    #(CLK_PERIOD*2);
    check("R11 irq at reset", 32'(irq), 32'h0);
    @(negedge clk); rst_n = 1;
    // R11 / R9: all registers zero, out-of-range slot zero
    for (int c = 0; c < 4; c++) begin
      rd(c, 0, "R11 ctrl after reset");
      rd(c, 1, "R11 status after reset");
    end
    // R2 / R1: plain control write stored whole, no interrupt
    wr(0, 0, 32'h0001_1234);
    rd(0, 0, "R2 control readback");
    rd(0, 1, "R1 status of core0 separate");
    wr(2, 0, 32'h3FFF_A5A5);
    rd(2, 0, "R2 control readback core2");
    // R4: core0 sends 0xBEEF to core1
    wr(0, 0, 32'h4001_BEEF);
    rd(1, 1, "R4 message at core1");
    check("R4 irq core1", 32'(irq), 32'h2);
    // R5: core2 overwrites core1 mailbox
    wr(2, 0, 32'h4001_0042);
    rd(1, 1, "R5 overwrite");
    check("R5 status value", stat_m[1], 32'h4002_0042);
    // R3: status write ignored
    wr(1, 1, 32'h0000_0000);
    rd(1, 1, "R3 status write ignored");
    check("R3 irq kept", 32'(irq), 32'h2);
    // R6: core1 acknowledges
    wr(1, 0, 32'h8000_0000);
    rd(1, 1, "R6 ack keeps src/payload");
    check("R6 ack value", stat_m[1], 32'h0002_0042);
    // R7: core2 sends to itself and acks in one write
    wr(2, 0, 32'hC002_5555);
    rd(2, 1, "R7 self gen+ack");
    check("R7 irq core2 low", 32'(irq[2]), 32'h0);
    // R7: core0 gen to core1 plus ack own (nothing pending)
    wr(0, 0, 32'hC001_7777);
    rd(1, 1, "R7 gen+ack other core");
    check("R7 irq core1 high", 32'(irq), 32'h2);
    // R10: destinations out of range
    wr(0, 0, 32'h4003_1111);
    wr(0, 0, 32'h7FFF_2222);
    for (int c = 0; c < N; c++) rd(c, 1, "R10 no update");
    check("R10 irq", 32'(irq), 32'h2);
    // R9: out-of-range writer has no effect
    wr(3, 0, 32'hC000_9999);
    rd(0, 1, "R9 oob write no effect");
    rd(3, 0, "R9 oob read zero");
    // R8: back-to-back reads, rdata holds between reads
    rd(0, 0, "R8 read latency");
    @(negedge clk);
    check("R8 rdata hold", rdata, ctrl_m[0]);
    rd(1, 1, "R8 next read");
    // R6: final ack of core1
    wr(1, 0, 32'h8000_0000);
    check("R6 irq cleared", 32'(irq), 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule